// File: doc/BRIEF.md
# Dual-Role SPI Port with Collision Detect

This block is a serial peripheral port that works either as the bus master or as a selected slave, all in one system clock domain. Software sets the role, the idle level of the serial clock, the phase (which of the two clock edges captures data), the character length and the baud divisor. It then hands over one character at a time on a parallel data path with a write strobe. Received characters come back on a parallel output, with a ready flag that stays set until it is acknowledged. Each pad (serial clock, master-out, master-in and the active-low select) has a separate input, output and output-enable signal, so the pad ring can be shared.

As master, the block divides the system clock to make the serial clock and drives it out. The select pin is either driven low for the length of the transfer, or watched as an input. In the second case, a low level on the select pin means a second master has taken the bus. The block then raises a sticky collision flag, drops its drivers and abandons the character. As slave, the incoming serial clock, select and data are resynchronised with two flops and their edges are found on the system clock. This sets a minimum serial clock period of eight system clocks. Clock activity is ignored while the slave is not selected.

Top module: `spi_port`

## Requirements
- R1: In master mode the serial clock changes level every `cfg_div`+1 system clocks during a character, is driven (`sck_oe`=1) only while busy, and rests at the level of `cfg_cpol` when idle.
- R2: A character is N bits long, where N is `cfg_nbits` for values 1 to 7 and 8 when `cfg_nbits` is 0. Bits travel most significant first. On transmit the sender uses `tx_data[N-1:0]`. The received character appears in `rx_data[N-1:0]` with the upper bits zero.
- R3: With `cfg_cpha`=0, data is captured on the leading edge (the edge leaving the idle level) and launched on the trailing edge. With `cfg_cpha`=1, data is launched on the leading edge and captured on the trailing edge. The first bit is valid half a clock period before its first capture edge. All four polarity and phase combinations carry the same data.
- R4: In slave mode, serial clock edges have no effect while `ss_n_i` is high. Any partial character count is held at zero.
- R5: In slave mode, select may stay low across several characters, with a new `tx_data` loaded between them. Raising select in the middle of a character discards that character without setting `rx_ready`.
- R6: In master mode with `cfg_ss_drive`=1, `ss_n_oe` is 1 and `ss_n_o` is low exactly while a character is in progress. With `cfg_ss_drive`=0, `ss_n_oe` is 0.
- R7: In master mode with `cfg_ss_drive`=0, a low `ss_n_i` sets `stat_collision`. It also clears `stat_busy`, turns off `sck_oe` and `mosi_oe`, and abandons the character. The flag stays set until `col_clr` is pulsed.
- R8: `stat_rx_ready` rises when a character completes and holds until `rx_ack`. A `tx_wr` while `stat_busy` is 1 is ignored.
- R9: After reset, `stat_busy`, `stat_rx_ready` and `stat_collision` are 0, and `sck_oe`, `mosi_oe` and `miso_oe` are 0.
- R10: `miso_oe` is 1 only in slave mode while the slave is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = capture on leading edge, 1 = capture on trailing edge |
| cfg_nbits | input | 3 | Character length (0 means 8) |
| cfg_div | input | 8 | Half period of the master clock minus one, in system clocks |
| cfg_ss_drive | input | 1 | Master drives select (1) or watches it for collisions (0) |
| tx_data | input | 8 | Character to send |
| tx_wr | input | 1 | Load/start strobe |
| rx_data | output | 8 | Last received character |
| rx_ack | input | 1 | Clears the receive-ready flag |
| col_clr | input | 1 | Clears the collision flag |
| stat_busy | output | 1 | Character in progress |
| stat_rx_ready | output | 1 | Received character waiting |
| stat_collision | output | 1 | Sticky collision flag |
| sck_i | input | 1 | Serial clock pad input |
| sck_o | output | 1 | Serial clock pad output |
| sck_oe | output | 1 | Serial clock pad enable |
| mosi_i | input | 1 | Master-out pad input |
| mosi_o | output | 1 | Master-out pad output |
| mosi_oe | output | 1 | Master-out pad enable |
| miso_i | input | 1 | Master-in pad input |
| miso_o | output | 1 | Master-in pad output |
| miso_oe | output | 1 | Master-in pad enable |
| ss_n_i | input | 1 | Select pad input (active low) |
| ss_n_o | output | 1 | Select pad output |
| ss_n_oe | output | 1 | Select pad enable |

## Verification
The bench covers all four polarity/phase pairings in both roles and runs short characters as well as full ones. A design that mixed up capture and launch edges, or shifted on the very first launch edge, would return rotated or bit-lost data. It also times the master clock half-period against the divisor, where an off-by-one shows up directly. For the slave, the bench toggles the clock while the slave is deselected and then checks the next real character. It also aborts a character part way through and runs back-to-back characters under one select. A slave that counted stray edges or kept a stale bit count would deliver shifted data or a false ready. Finally, a second master's select is forced low mid-character, and the bench expects the drivers to release and the flag to stay set until it is cleared.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  // Classification of a serial clock transition relative to the idle level
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } sck_edge_t;

  // Capture on leading edge when phase is 0, on trailing edge when phase is 1
  function automatic logic edge_captures(sck_edge_t e, logic cpha);
    return (e == EDGE_LEAD) ? !cpha : ((e == EDGE_TRAIL) ? cpha : 1'b0);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/spi_baud.sv
module spi_baud #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] cnt_d;

  assign tick = en && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en && $stable(div) |-> cnt_q <= div); // R1
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8,
  localparam int NBW = $clog2(DW),
  localparam int ECW = $clog2(2 * DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [NBW-1:0]  cfg_nbits,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_ss_drive,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_wr,
  output logic [DW-1:0]   rx_data,
  input  logic            rx_ack,
  input  logic            col_clr,
  output logic            stat_busy,
  output logic            stat_rx_ready,
  output logic            stat_collision,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            mosi_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            miso_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            ss_n_i,
  output logic            ss_n_o,
  output logic            ss_n_oe
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // Pad inputs resynchronised: {sck, mosi, ss_n}
  logic sck_s, mosi_s, ss_s;
  spi_sync #(.W(3), .RST(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({sck_i, mosi_i, ss_n_i}),
    .q({sck_s, mosi_s, ss_s})
  );

  // State
  logic          busy_q, busy_d;
  logic [ECW-1:0] ecnt_q, ecnt_d;
  logic [ECW-1:0] scnt_q, scnt_d;
  logic          sck_q, sck_d;
  logic          sck_prev_q;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] rxdat_q, rxdat_d;
  logic          rdy_q, rdy_d;
  logic          col_q, col_d;

  logic baud_tick;
  spi_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_ni),
    .en(cfg_master && busy_q),
    .div(cfg_div),
    .tick(baud_tick)
  );

  // Derived character geometry
  logic [ECW-1:0] nlen, last_bit, last_edge;
  assign nlen      = (cfg_nbits == '0) ? ECW'(DW) : ECW'(cfg_nbits);
  assign last_bit  = nlen - 1'b1;
  assign last_edge = ECW'({nlen, 1'b0} - 1'b1);

  // Edge events, role selected
  logic      slave_sel, col_det, busy_o;
  sck_edge_t m_edge, s_edge, edge_ev;
  logic      capture, launch, in_bit;
  logic [DW-1:0] rx_shift;

  assign slave_sel = !cfg_master && !ss_s;
  assign col_det   = cfg_master && !cfg_ss_drive && !ss_s;

  always_comb begin
    m_edge = EDGE_NONE;
    if (busy_q && baud_tick) m_edge = (sck_q == cfg_cpol) ? EDGE_LEAD : EDGE_TRAIL;
    s_edge = EDGE_NONE;
    if (slave_sel && (sck_s != sck_prev_q)) s_edge = (sck_s != cfg_cpol) ? EDGE_LEAD : EDGE_TRAIL;
  end

  assign edge_ev  = cfg_master ? m_edge : s_edge;
  assign capture  = edge_captures(edge_ev, cfg_cpha);
  assign launch   = (edge_ev != EDGE_NONE) && !capture;
  assign in_bit   = cfg_master ? miso_i : mosi_s;
  assign rx_shift = {rx_q[DW-2:0], in_bit};
  assign busy_o   = cfg_master ? busy_q : (scnt_q != '0);

  // Next state
  always_comb begin
    busy_d  = busy_q;
    ecnt_d  = ecnt_q;
    scnt_d  = scnt_q;
    sck_d   = sck_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    rxdat_d = rxdat_q;
    rdy_d   = rdy_q;
    col_d   = col_q;

    if (rx_ack)  rdy_d = 1'b0;
    if (col_clr) col_d = 1'b0;
    if (!busy_q) sck_d = cfg_cpol;

    if (tx_wr && !busy_o && !col_det) begin
      tx_d = tx_data << (DW - int'(nlen));
      if (cfg_master) begin
        busy_d = 1'b1;
        ecnt_d = '0;
        scnt_d = '0;
        rx_d   = '0;
        sck_d  = cfg_cpol;
      end
    end

    if (capture) begin
      rx_d = rx_shift;
      if (scnt_q == last_bit) begin
        rxdat_d = rx_shift;
        rdy_d   = 1'b1;
        rx_d    = '0;
        scnt_d  = '0;
      end else begin
        scnt_d = scnt_q + 1'b1;
      end
    end

    // First bit is already on the line; shift only mid-character
    if (launch && (scnt_q != '0)) tx_d = {tx_q[DW-2:0], 1'b0};

    if (m_edge != EDGE_NONE) begin
      sck_d  = !sck_q;
      ecnt_d = ecnt_q + 1'b1;
      if (ecnt_q == last_edge) busy_d = 1'b0;
    end

    if (!cfg_master && ss_s) begin
      scnt_d = '0;
      rx_d   = '0;
    end

    if (col_det) begin
      col_d  = 1'b1;
      busy_d = 1'b0;
      scnt_d = '0;
      rx_d   = '0;
      sck_d  = cfg_cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ecnt_q     <= '0;
      scnt_q     <= '0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      tx_q       <= '0;
      rx_q       <= '0;
      rxdat_q    <= '0;
      rdy_q      <= 1'b0;
      col_q      <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      ecnt_q     <= ecnt_d;
      scnt_q     <= scnt_d;
      sck_q      <= sck_d;
      sck_prev_q <= sck_s;
      tx_q       <= tx_d;
      rx_q       <= rx_d;
      rxdat_q    <= rxdat_d;
      rdy_q      <= rdy_d;
      col_q      <= col_d;
    end
  end

  // Outputs
  assign rx_data        = rxdat_q;
  assign stat_busy      = busy_o;
  assign stat_rx_ready  = rdy_q;
  assign stat_collision = col_q;
  assign sck_o          = sck_q;
  assign sck_oe         = cfg_master && busy_q;
  assign mosi_o         = tx_q[DW-1];
  assign mosi_oe        = cfg_master && busy_q;
  assign miso_o         = tx_q[DW-1];
  assign miso_oe        = slave_sel;
  assign ss_n_o         = !busy_q;
  assign ss_n_oe        = cfg_master && cfg_ss_drive;

  // Checks
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_master && !busy_q && $past(!busy_q) && $stable(cfg_cpol) |-> sck_o == cfg_cpol); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    $stable(cfg_nbits) && $stable(cfg_master) && $past(scnt_q < nlen) |-> scnt_q < nlen); // R2
  AST_SS_IGNORE: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_master && ss_s |=> scnt_q == '0); // R4
  AST_COL_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(col_q) |-> !sck_oe && !mosi_oe && !stat_busy); // R7
  AST_COL_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    col_q && !col_clr |=> col_q); // R7
  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    rdy_q && !rx_ack |=> rdy_q); // R8
  AST_MISO_ROLE: assert property (@(posedge clk) disable iff (!rst_ni)
    miso_oe |-> !cfg_master && !ss_s); // R10
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       cfg_master, cfg_cpol, cfg_cpha, cfg_ss_drive;
  logic [2:0] cfg_nbits;
  logic [7:0] cfg_div;
  logic [7:0] tx_data, rx_data;
  logic       tx_wr, rx_ack, col_clr;
  logic       stat_busy, stat_rx_ready, stat_collision;
  logic       sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe, ss_n_i, ss_n_o, ss_n_oe;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_nbits(cfg_nbits), .cfg_div(cfg_div), .cfg_ss_drive(cfg_ss_drive),
    .tx_data(tx_data), .tx_wr(tx_wr), .rx_data(rx_data), .rx_ack(rx_ack),
    .col_clr(col_clr), .stat_busy(stat_busy), .stat_rx_ready(stat_rx_ready),
    .stat_collision(stat_collision),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side slave for master-mode runs: samples MOSI and shifts reply on capture edges
  logic       mact = 1'b0;
  logic [7:0] rep, got;
  always @(sck_o) begin
    if (mact && ((sck_o != cfg_cpol) != cfg_cpha)) begin
      got    = {got[6:0], mosi_o};
      rep    = {rep[6:0], 1'b0};
      miso_i = rep[7];
    end
  end

  localparam int H = 4;  // half period of bench-driven serial clock, in system clocks

  task automatic wait_idle();
    for (int k = 0; k < 3000 && stat_busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic ack();
    rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic set_cfg(input logic m, input logic p, input logic h, input logic [2:0] nb);
    cfg_master = m; cfg_cpol = p; cfg_cpha = h; cfg_nbits = nb;
    sck_i = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic master_start(input logic [7:0] txd, input logic [7:0] oth, input int n);
    rep = oth << (8 - n); miso_i = rep[7]; got = '0;
    mact = 1'b1;
    pulse_wr(txd);
  endtask

  // Bench acts as master towards the slave, cnt bits MSB first
  task automatic slave_bits(input int cnt, input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    ss_n_i = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = cnt - 1; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi_i = mo[i];
        repeat (H) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sck_i = ~cfg_cpol;
        repeat (H) @(negedge clk);
        sck_i = cfg_cpol;
      end else begin
        sck_i = ~cfg_cpol; mosi_i = mo[i];
        repeat (H) @(negedge clk);
        mi = {mi[6:0], miso_o};
        sck_i = cfg_cpol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
  endtask

  // {master, cpol, cpha, nbits[2:0], tx[7:0], other[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 3'd0, 8'hA5, 8'h3C},
    {1'b1, 1'b1, 1'b0, 3'd0, 8'h96, 8'hE1},
    {1'b1, 1'b0, 1'b1, 3'd5, 8'h1B, 8'h15},
    {1'b1, 1'b1, 1'b1, 3'd3, 8'h06, 8'h05},
    {1'b0, 1'b0, 1'b0, 3'd0, 8'hC3, 8'h5A},
    {1'b0, 1'b1, 1'b1, 3'd0, 8'h7E, 8'h81},
    {1'b0, 1'b0, 1'b1, 3'd7, 8'h55, 8'h2A},
    {1'b0, 1'b1, 1'b0, 3'd4, 8'h09, 8'h06}
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] mi, mi2;
    int c;
    logic s;
    rst_n = 1'b0; cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_nbits = 3'd0; cfg_div = 8'd3; cfg_ss_drive = 1'b1;
    tx_data = '0; tx_wr = 1'b0; rx_ack = 1'b0; col_clr = 1'b0;
    sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; ss_n_i = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(!stat_busy && !stat_rx_ready && !stat_collision, "R9 status", {stat_busy, stat_rx_ready, stat_collision}, 0);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R9 enables", {sck_oe, mosi_oe, miso_oe}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Vector walk: both roles, four modes, several lengths (R2, R3)
    for (int v = 0; v < 8; v++) begin
      logic [7:0] txd, oth, msk;
      int n;
      txd = VEC[v][15:8]; oth = VEC[v][7:0];
      n = (VEC[v][18:16] == 3'd0) ? 8 : int'(VEC[v][18:16]);
      msk = 8'((1 << n) - 1);
      set_cfg(VEC[v][21], VEC[v][20], VEC[v][19], VEC[v][18:16]);
      if (VEC[v][21]) begin
        master_start(txd, oth, n);
        wait_idle();
        mact = 1'b0;
        chk(rx_data == (oth & msk), "R2 master rx", rx_data, oth & msk);
        chk((got & msk) == (txd & msk), "R3 master mosi", got & msk, txd & msk);
      end else begin
        pulse_wr(txd);
        slave_bits(n, oth, mi);
        ss_n_i = 1'b1;
        repeat (H) @(negedge clk);
        chk(rx_data == (oth & msk), "R2 slave rx", rx_data, oth & msk);
        chk(mi == (txd & msk), "R3 slave miso", mi, txd & msk);
      end
      chk(stat_rx_ready, "R8 ready set", stat_rx_ready, 1);
      ack();
    end
    chk(!stat_rx_ready, "R8 ack clears", stat_rx_ready, 0);

    // R1 divider timing, R6 select drive, R8 write ignored while busy
    cfg_div = 8'd2; cfg_ss_drive = 1'b1;
    set_cfg(1'b1, 1'b0, 1'b0, 3'd0);
    master_start(8'h3C, 8'h00, 8);
    c = 0;
    while (sck_o == cfg_cpol && c < 50) begin @(negedge clk); c++; end
    chk(c == 3, "R1 first half", c, 3);
    s = sck_o; c = 0;
    while (sck_o == s && c < 50) begin @(negedge clk); c++; end
    chk(c == 3, "R1 half period", c, 3);
    chk(sck_oe && mosi_oe, "R1 drive on", {sck_oe, mosi_oe}, 3);
    chk(!ss_n_o && ss_n_oe, "R6 select low", {ss_n_o, ss_n_oe}, 1);
    pulse_wr(8'hFF);
    wait_idle();
    mact = 1'b0;
    chk(got == 8'h3C, "R8 write while busy", got, 8'h3C);
    chk(ss_n_o && ss_n_oe, "R6 select released", {ss_n_o, ss_n_oe}, 3);
    chk(sck_o == 1'b0 && !sck_oe, "R1 idle", {sck_o, sck_oe}, 0);
    ack();

    // R7 collision
    cfg_div = 8'd3; cfg_ss_drive = 1'b0; ss_n_i = 1'b1;
    set_cfg(1'b1, 1'b1, 1'b0, 3'd0);
    chk(!ss_n_oe, "R6 select as input", ss_n_oe, 0);
    pulse_wr(8'h77);
    repeat (10) @(negedge clk);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(stat_collision && !stat_busy, "R7 flag and abort", {stat_collision, stat_busy}, 2);
    chk(!sck_oe && !mosi_oe, "R7 drivers off", {sck_oe, mosi_oe}, 0);
    ss_n_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(stat_collision, "R7 sticky", stat_collision, 1);
    col_clr = 1'b1; @(negedge clk); col_clr = 1'b0;
    chk(!stat_collision, "R7 clear", stat_collision, 0);
    chk(!stat_rx_ready, "R7 no ready", stat_rx_ready, 0);
    cfg_ss_drive = 1'b1;

    // R4 / R10 deselected slave ignores the clock
    set_cfg(1'b0, 1'b0, 1'b0, 3'd0);
    pulse_wr(8'hA5);
    ss_n_i = 1'b1;
    for (int t = 0; t < 8; t++) begin
      sck_i = ~sck_i; mosi_i = t[0];
      repeat (H) @(negedge clk);
    end
    sck_i = 1'b0;
    repeat (H) @(negedge clk);
    chk(!stat_busy && !stat_rx_ready, "R4 no effect", {stat_busy, stat_rx_ready}, 0);
    chk(!miso_oe, "R10 miso off", miso_oe, 0);
    slave_bits(8, 8'h3C, mi);
    chk(miso_oe, "R10 miso on", miso_oe, 1);
    ss_n_i = 1'b1;
    repeat (H) @(negedge clk);
    chk(rx_data == 8'h3C && mi == 8'hA5, "R4 clean char", {rx_data, mi}, 16'h3CA5);
    ack();

    // R5 back-to-back under one select
    set_cfg(1'b0, 1'b0, 1'b1, 3'd0);
    pulse_wr(8'h81);
    slave_bits(8, 8'h11, mi);
    chk(rx_data == 8'h11 && mi == 8'h81, "R5 first of pair", {rx_data, mi}, 16'h1181);
    ack();
    pulse_wr(8'h42);
    slave_bits(8, 8'h99, mi2);
    chk(rx_data == 8'h99 && mi2 == 8'h42, "R5 second of pair", {rx_data, mi2}, 16'h9942);
    ss_n_i = 1'b1;
    ack();

    // R5 abort mid-character
    set_cfg(1'b0, 1'b1, 1'b0, 3'd0);
    pulse_wr(8'hF0);
    slave_bits(3, 8'h05, mi);
    ss_n_i = 1'b1;
    repeat (H) @(negedge clk);
    chk(!stat_busy && !stat_rx_ready, "R5 abort discards", {stat_busy, stat_rx_ready}, 0);
    pulse_wr(8'h0F);
    slave_bits(8, 8'hC6, mi);
    ss_n_i = 1'b1;
    repeat (H) @(negedge clk);
    chk(rx_data == 8'hC6 && mi == 8'h0F, "R5 after abort", {rx_data, mi}, 16'hC60F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule